// File: doc/BRIEF.md
# Work-Group Barrier Buffer

This block is one stage of a handshaked streaming datapath. It holds work-items at a synchronisation point until their whole work-group has gathered. Each work-item arrives with a payload word that carries its live variables, a group identifier and a local identifier. The block stores all three. It keeps back every item of a group until the number of stored members of that group equals the group size, which is given as a run-time input. It then lets the members out one per cycle, in the order they came in.

Members of one group are expected to arrive back to back. Under that rule the storage only ever needs to cover one group plus whatever of the previous group is still draining, so its depth is a parameter at least as large as the biggest group size. A count of groups that are complete but not yet fully released lets the next group fill while the one before it drains. An item that breaks the back-to-back rule sets an error flag, which stays set until reset.

Top module: `barrier_buffer`

## Requirements
- R1: The payload, group ID and local ID of every item are delivered at the output exactly as they were accepted at the input.
- R2: While fewer than `grpSize` items of the group at the head of storage have been accepted, `outValid` stays low. When the last member is accepted on a clock edge, `outValid` is high after that edge.
- R3: Items leave one per output handshake, in the same order in which they were accepted, across group boundaries. Every accepted item leaves exactly once.
- R4: `inReady` is low exactly when `DEPTH` items are stored, and no item is accepted while it is low.
- R5: A new group can be accepted in the same cycles in which items of an earlier complete group are being released.
- R6: If an item is accepted with a group ID that differs from the group ID of the first member of a group that is still incomplete, `seqError` goes high on the next edge. It then stays high until reset. A new group ID on the first item of a group does not set it.
- R7: With `grpSize` equal to 1, every accepted item makes `outValid` high immediately after the accepting edge.
- R8: After reset `outValid` is low, `inReady` is high and `seqError` is low.
- R9: While `outValid` is high and `outReady` is low, `outValid`, `outData`, `outGid` and `outLid` keep their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| grpSize | input | $clog2(DEPTH+1) | Members per work-group (1..DEPTH), held steady during use |
| inValid | input | 1 | Upstream offers an item |
| inReady | output | 1 | Block can accept an item |
| inData | input | DATA_W | Live-variable payload of the offered item |
| inGid | input | GID_W | Work-group ID of the offered item |
| inLid | input | LID_W | Local ID of the offered item |
| outValid | output | 1 | A released item is offered downstream |
| outReady | input | 1 | Downstream accepts the offered item |
| outData | output | DATA_W | Payload of the released item |
| outGid | output | GID_W | Work-group ID of the released item |
| outLid | output | LID_W | Local ID of the released item |
| seqError | output | 1 | Sticky flag for a group that arrived out of sequence |

## Verification
An accepted item that completes its group makes `outValid` high right after the accepting edge, with no extra stage. A released item is replaced at the output right after the popping edge. `seqError` rises on the edge that accepts the offending item. The bench drives and samples on the falling edge. There it reads the outputs that the last rising edge produced, works out the handshakes the coming edge will perform from the values it has just driven, and updates its own occupancy count and release cursor so that each comparison is made exactly one edge later. A sweep over every group size from 1 to the depth checks the gating while a group fills. It then streams two more groups against a stalling output pattern and compares each released item with values computed from its group and local index.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  typedef struct packed {
    logic push;
    logic pop;
  } strobe_t;
endpackage

// File: rtl/barrier_store.sv
module barrier_store #(
  parameter int DATA_W = 16,
  parameter int GID_W  = 4,
  parameter int LID_W  = 4,
  parameter int DEPTH  = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  barrier_pkg::strobe_t       strobe,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [GID_W-1:0]           wrGid,
  input  logic [LID_W-1:0]           wrLid,
  output logic [DATA_W-1:0]          rdData,
  output logic [GID_W-1:0]           rdGid,
  output logic [LID_W-1:0]           rdLid,
  output logic                       full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = DATA_W + GID_W + LID_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {wrData, wrGid, wrLid};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  assign {rdData, rdGid, rdLid} = mem[rdPtr];
  assign full = (count == CNT_W'(DEPTH));
endmodule

// File: rtl/barrier_ctrl.sv
module barrier_ctrl #(
  parameter int GID_W = 4,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(DEPTH+1)-1:0]   grpSize,
  input  logic                         inValid,
  input  logic [GID_W-1:0]             inGid,
  input  logic                         outReady,
  input  logic                         full,
  output logic                         inReady,
  output logic                         outValid,
  output logic                         seqError,
  output barrier_pkg::strobe_t         strobe
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W-1:0] arrCnt;      // members of the filling group seen so far
  logic [CNT_W-1:0] relCnt;      // members of the head group released so far
  logic [CNT_W-1:0] readyGroups; // complete groups not yet fully released
  logic [GID_W-1:0] curGid;
  logic             arrLast, relLast, midGroup;

  assign inReady    = !full;
  assign outValid   = (readyGroups != '0);
  assign strobe.push = inValid && inReady;
  assign strobe.pop  = outValid && outReady;

  // a size of zero behaves as one, so the counters can never stall
  assign arrLast  = (({1'b0, arrCnt} + ONE) >= {1'b0, grpSize});
  assign relLast  = (({1'b0, relCnt} + ONE) >= {1'b0, grpSize});
  assign midGroup = (arrCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      arrCnt      <= '0;
      relCnt      <= '0;
      readyGroups <= '0;
      curGid      <= '0;
      seqError    <= 1'b0;
    end else begin
      if (strobe.push) begin
        arrCnt <= arrLast ? '0 : arrCnt + CNT_W'(1);
        if (!midGroup) curGid <= inGid;
        if (midGroup && (inGid != curGid)) seqError <= 1'b1;
      end
      if (strobe.pop) relCnt <= relLast ? '0 : relCnt + CNT_W'(1);
      case ({strobe.push && arrLast, strobe.pop && relLast})
        2'b10:   readyGroups <= readyGroups + CNT_W'(1);
        2'b01:   readyGroups <= readyGroups - CNT_W'(1);
        default: readyGroups <= readyGroups;
      endcase
    end
  end
endmodule

// File: rtl/barrier_buffer.sv
module barrier_buffer #(
  parameter int DATA_W = 16,
  parameter int GID_W  = 4,
  parameter int LID_W  = 4,
  parameter int DEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [$clog2(DEPTH+1)-1:0]   grpSize,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [DATA_W-1:0]            inData,
  input  logic [GID_W-1:0]             inGid,
  input  logic [LID_W-1:0]             inLid,
  output logic                         outValid,
  input  logic                         outReady,
  output logic [DATA_W-1:0]            outData,
  output logic [GID_W-1:0]             outGid,
  output logic [LID_W-1:0]             outLid,
  output logic                         seqError
);
  barrier_pkg::strobe_t strobe;
  logic full;

  barrier_ctrl #(.GID_W(GID_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .grpSize(grpSize), .inValid(inValid),
    .inGid(inGid), .outReady(outReady), .full(full), .inReady(inReady),
    .outValid(outValid), .seqError(seqError), .strobe(strobe)
  );

  barrier_store #(.DATA_W(DATA_W), .GID_W(GID_W), .LID_W(LID_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(inData), .wrGid(inGid),
    .wrLid(inLid), .rdData(outData), .rdGid(outGid), .rdLid(outLid), .full(full)
  );
endmodule

// File: rtl/barrier_buffer_chk.sv
module barrier_buffer_chk #(
  parameter int DATA_W = 16,
  parameter int GID_W  = 4,
  parameter int LID_W  = 4,
  parameter int DEPTH  = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [$clog2(DEPTH+1)-1:0]   grpSize,
  input logic                         inValid,
  input logic                         inReady,
  input logic                         outValid,
  input logic                         outReady,
  input logic [DATA_W-1:0]            outData,
  input logic [GID_W-1:0]             outGid,
  input logic [LID_W-1:0]             outLid,
  input logic                         seqError
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  logic [CNT_W:0] occ; // occupancy seen from the port handshakes

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occ <= '0;
    else occ <= occ + (CNT_W+1)'(inValid && inReady) - (CNT_W+1)'(outValid && outReady);
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (occ == (CNT_W+1)'(DEPTH)) |-> !inReady);
  assert_occ_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    occ <= (CNT_W+1)'(DEPTH));
  assert_release_nonempty_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (occ != '0));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outGid) && $stable(outLid)));
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    seqError |=> seqError);
  assert_single_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((grpSize == CNT_W'(1)) && inValid && inReady) |=> outValid);
endmodule

bind barrier_buffer barrier_buffer_chk #(
  .DATA_W(DATA_W), .GID_W(GID_W), .LID_W(LID_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rstN(rstN), .grpSize(grpSize), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outData(outData), .outGid(outGid),
  .outLid(outLid), .seqError(seqError)
);

// File: tb/barrier_buffer_tb.sv
module barrier_buffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int GID_W  = 4;
  localparam int LID_W  = 4;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] grpSize = '0;
  logic inValid = 1'b0, outReady = 1'b0;
  logic [DATA_W-1:0] inData = '0;
  logic [GID_W-1:0] inGid = '0;
  logic [LID_W-1:0] inLid = '0;
  logic inReady, outValid, seqError;
  logic [DATA_W-1:0] outData;
  logic [GID_W-1:0] outGid;
  logic [LID_W-1:0] outLid;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrier_buffer #(.DATA_W(DATA_W), .GID_W(GID_W), .LID_W(LID_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .grpSize(grpSize), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inGid(inGid), .inLid(inLid), .outValid(outValid),
    .outReady(outReady), .outData(outData), .outGid(outGid), .outLid(outLid),
    .seqError(seqError)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int gidOf(input int s, input int g);
    return (s * 3 + g) % 16;
  endfunction

  function automatic int payOf(input int s, input int g, input int l);
    return (g * 37 + l * 5 + s * 11 + 1) % 65536;
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pushOne(input int gid, input int lid);
    inValid = 1'b1; inGid = GID_W'(gid); inLid = LID_W'(lid); inData = DATA_W'(lid + 100);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    doReset();
    // R8: state after reset
    check(outValid == 1'b0, "R8 outValid", int'(outValid), 0);
    check(inReady == 1'b1, "R8 inReady", int'(inReady), 1);
    check(seqError == 1'b0, "R8 seqError", int'(seqError), 0);

    for (int s = 1; s <= DEPTH; s++) begin
      int occ, pushIdx, pops, cyc;
      bit overlap, held;
      logic [DATA_W-1:0] hData;
      logic [GID_W-1:0] hGid;
      logic [LID_W-1:0] hLid;
      doReset();
      grpSize = CNT_W'(s);
      // fill group 0 with the output stalled: R2 gating
      for (int l = 0; l < s; l++) begin
        check(outValid == 1'b0, "R2 early release", int'(outValid), 0);
        inValid = 1'b1; inGid = GID_W'(gidOf(s, 0)); inLid = LID_W'(l);
        inData = DATA_W'(payOf(s, 0, l));
        @(negedge clk);
      end
      inValid = 1'b0;
      check(outValid == 1'b1, (s == 1) ? "R7 single release" : "R2 release", int'(outValid), 1);
      // stream groups 1 and 2 while group 0 drains
      occ = s; pushIdx = s; pops = 0; cyc = 0; overlap = 0; held = 0;
      hData = '0; hGid = '0; hLid = '0;
      while (pops < 3 * s && cyc < 2000) begin
        bit doPush, doPop;
        if (held) begin
          check(outValid && outData == hData && outGid == hGid && outLid == hLid,
                "R9 hold", int'(outData), int'(hData));
        end
        check(inReady == (occ < DEPTH), "R4 ready", int'(inReady), int'(occ < DEPTH));
        outReady = (cyc % 3 != 2);
        if (pushIdx < 3 * s) begin
          inValid = 1'b1;
          inGid = GID_W'(gidOf(s, pushIdx / s)); inLid = LID_W'(pushIdx % s);
          inData = DATA_W'(payOf(s, pushIdx / s, pushIdx % s));
        end else inValid = 1'b0;
        doPush = inValid && inReady;
        doPop = outValid && outReady;
        if (doPop) begin
          check(outData == DATA_W'(payOf(s, pops / s, pops % s)), "R1 payload",
                int'(outData), payOf(s, pops / s, pops % s));
          check(outGid == GID_W'(gidOf(s, pops / s)) && outLid == LID_W'(pops % s),
                "R3 order", int'({outGid, outLid}), int'({GID_W'(gidOf(s, pops / s)), LID_W'(pops % s)}));
          pops++;
        end
        held = outValid && !outReady;
        hData = outData; hGid = outGid; hLid = outLid;
        if (doPush && outValid) overlap = 1;
        occ = occ + int'(doPush) - int'(doPop);
        pushIdx = pushIdx + int'(doPush);
        cyc++;
        @(negedge clk);
      end
      inValid = 1'b0; outReady = 1'b0;
      check(pops == 3 * s, "R3 count", pops, 3 * s);
      check(outValid == 1'b0, "R3 drained", int'(outValid), 0);
      check(overlap, "R5 overlap", int'(overlap), 1);
      check(seqError == 1'b0, "R6 no false error", int'(seqError), 0);
    end

    // R6: out-of-sequence group ID mid group
    doReset();
    grpSize = CNT_W'(4);
    pushOne(3, 0);
    check(seqError == 1'b0, "R6 first item", int'(seqError), 0);
    pushOne(3, 1);
    check(seqError == 1'b0, "R6 same group", int'(seqError), 0);
    pushOne(9, 2);
    check(seqError == 1'b1, "R6 set", int'(seqError), 1);
    pushOne(9, 3);
    check(seqError == 1'b1, "R6 sticky", int'(seqError), 1);
    repeat (3) @(negedge clk);
    check(seqError == 1'b1, "R6 sticky idle", int'(seqError), 1);
    doReset();
    check(seqError == 1'b0, "R8 error cleared", int'(seqError), 0);
    check(outValid == 1'b0, "R8 outValid again", int'(outValid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nChecks++; nErr++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule